// File: doc/BRIEF.md
# Single-Scan Conversion Queue Sequencer

This block walks a short list of conversion command words exactly once each time software arms it. Each command word names an input channel and may carry a pause flag. The sequencer holds the arming bit and waits for the start condition that the selected operating mode requires: an immediate internal start, a rising edge on an external trigger pin, or the expiry of a programmable interval timer. It then reads command words from entry 0 onward and issues one request per word to an analog converter. The converter is modelled as a request/done handshake. The scan ends at an end-of-queue code or after the last entry. At that point the arming bit clears itself and the queue returns to idle.

The command words sit in a small internal memory that is loaded through a write port. Software watches the queue status (idle, active, paused) and a sticky flag. The flag records any trigger that arrived while the queue was still running in a trigger-driven mode. Changing the operating mode cancels any scan in progress at once.

Top module: `scan_queue_seq`

## Requirements
- R1: After synchronous reset the arming bit, the overrun flag and the conversion request are 0, and the status reads idle.
- R2: In software mode (mode 1), setting the arming bit while idle starts a scan with no external event. Entries are read in ascending order from 0. Each entry raises one request carrying its channel field (bits [CH_W-1:0]), and that request is held until done is seen.
- R3: A scan ends without a conversion at an entry whose channel field is all ones, or after the last entry has been converted.
- R4: When a scan ends, the hardware clears the arming bit and the status returns to idle (0).
- R5: Writes to the arming bit while a scan is active or paused leave the bit and the running scan unchanged.
- R6: In external mode (mode 2), an armed idle queue starts only on a rising edge of the external trigger input. An edge that arrives while the queue is unarmed starts nothing.
- R7: In timer mode (mode 3), a down-counter reloads with the period input and expires every period+1 cycles. Each expiry acts as the start trigger.
- R8: In external or timer mode, once an entry whose pause bit (bit CH_W) is set has been converted, the status reads pause. The queue then waits for the next trigger and continues with the following entry.
- R9: In software mode a pause bit never stops the scan: the status never reads pause.
- R10: A trigger that arrives while a scan is executing (not paused) in external or timer mode sets a sticky overrun flag. A clear strobe resets the flag. No such flag is set in software mode.
- R11: A change of mode input aborts the scan at once: on the next cycle the request is low and the status is idle. The arming bit keeps its value, and the new mode acts on it straight away.
- R12: Mode codes are 0 off, 1 software, 2 external, 3 timer. Status codes are 0 idle, 1 active, 2 pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode |
| arm_wr_i | input | 1 | Write strobe for the arming bit |
| arm_val_i | input | 1 | Value written to the arming bit |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| tmr_period_i | input | TMR_W | Interval timer reload value |
| cw_we_i | input | 1 | Command memory write enable |
| cw_addr_i | input | AW | Command memory write address |
| cw_data_i | input | CH_W+1 | Command word: pause bit over channel field |
| conv_req_o | output | 1 | Conversion request |
| conv_ch_o | output | CH_W | Channel of the current request |
| conv_done_i | input | 1 | Converter finished the current request |
| arm_o | output | 1 | Arming bit |
| status_o | output | 2 | Queue status |
| ovr_o | output | 1 | Sticky trigger overrun flag |

## Verification
Random queues of random length, with random pause bits and random converter latency, are run in software mode. These runs show whether the request order and the end-of-queue handling match the loaded words. Directed queues cover an end marker at entry 0, a full queue with no marker, and pauses in each mode. Together they separate the marker-based end from the end at the last entry, and the skipped pause from the held pause. Stalled conversions hold the scan open so that mid-scan arm writes, extra triggers and mode changes land at a known point. These cases separate ignored writes, overrun capture and abort from normal completion.

// File: rtl/sqs_pkg.sv
package sqs_pkg;
  typedef enum logic [1:0] {M_OFF = 2'd0, M_SW = 2'd1, M_EXT = 2'd2, M_TMR = 2'd3} mode_e;
  typedef enum logic [1:0] {Q_IDLE = 2'd0, Q_ACTIVE = 2'd1, Q_PAUSE = 2'd2} qstat_e;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DECODE, S_BUSY, S_PAUSE} seq_st_e;
endpackage

// File: rtl/sqs_cwmem.sv
module sqs_cwmem #(
  parameter int DEPTH = 16,
  parameter int CW_W  = 7,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [CW_W-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [CW_W-1:0] rdata
);
  logic [CW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sqs_trig.sv
module sqs_trig
  import sqs_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             ext_i,
  input  logic [TMR_W-1:0] period_i,
  output logic             trig_o
);
  logic [2:0]       sync_q;
  logic [TMR_W-1:0] cnt_q;
  logic             rise, expire;

  assign rise   = sync_q[1] & ~sync_q[2];
  assign expire = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      cnt_q  <= '0;
      trig_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ext_i};
      if (mode_e'(mode_i) != M_TMR || expire) cnt_q <= period_i;
      else                                    cnt_q <= cnt_q - 1'b1;
      trig_o <= (mode_e'(mode_i) == M_EXT && rise) ||
                (mode_e'(mode_i) == M_TMR && expire);
    end
  end

  p_single_edge_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/sqs_ctrl.sv
module sqs_ctrl
  import sqs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CH_W  = 6,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode_i,
  input  logic            arm_wr_i,
  input  logic            arm_val_i,
  input  logic            ovr_clr_i,
  input  logic            trig_i,
  output logic [AW-1:0]   rd_addr_o,
  input  logic [CH_W:0]   rd_data_i,
  output logic            conv_req_o,
  output logic [CH_W-1:0] conv_ch_o,
  input  logic            conv_done_i,
  output logic            arm_o,
  output logic [1:0]      status_o,
  output logic            ovr_o
);
  localparam logic [CH_W-1:0] EOQ  = {CH_W{1'b1}};
  localparam logic [AW-1:0]   LAST = AW'(DEPTH - 1);

  seq_st_e         st_q;
  mode_e           mode_n, mode_q;
  logic [AW-1:0]   ptr_q;
  logic            arm_q, ovr_q, pz_q;
  logic            mode_chg, executing, trig_mode;

  assign mode_n    = mode_e'(mode_i);
  assign mode_chg  = (mode_n != mode_q);
  assign executing = (st_q == S_FETCH) || (st_q == S_DECODE) || (st_q == S_BUSY);
  assign trig_mode = (mode_q == M_EXT) || (mode_q == M_TMR);
  assign rd_addr_o = ptr_q;
  assign arm_o     = arm_q;
  assign ovr_o     = ovr_q;

  always_comb begin
    case (st_q)
      S_IDLE:  status_o = Q_IDLE;
      S_PAUSE: status_o = Q_PAUSE;
      default: status_o = Q_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      mode_q     <= M_OFF;
      ptr_q      <= '0;
      arm_q      <= 1'b0;
      ovr_q      <= 1'b0;
      pz_q       <= 1'b0;
      conv_req_o <= 1'b0;
      conv_ch_o  <= '0;
    end else begin
      mode_q <= mode_n;
      if (ovr_clr_i) ovr_q <= 1'b0;
      if (trig_i && executing && !mode_chg && trig_mode) ovr_q <= 1'b1;
      if (arm_wr_i && st_q == S_IDLE) arm_q <= arm_val_i;
      if (mode_chg) begin
        st_q       <= S_IDLE;
        ptr_q      <= '0;
        conv_req_o <= 1'b0;
      end else begin
        case (st_q)
          S_IDLE:
            if (arm_q && (mode_q == M_SW || (trig_mode && trig_i))) begin
              ptr_q <= '0;
              st_q  <= S_FETCH;
            end
          S_FETCH: st_q <= S_DECODE;
          S_DECODE:
            if (rd_data_i[CH_W-1:0] == EOQ) begin
              arm_q <= 1'b0;
              st_q  <= S_IDLE;
            end else begin
              conv_req_o <= 1'b1;
              conv_ch_o  <= rd_data_i[CH_W-1:0];
              pz_q       <= rd_data_i[CH_W];
              st_q       <= S_BUSY;
            end
          S_BUSY:
            if (conv_done_i) begin
              conv_req_o <= 1'b0;
              if (ptr_q == LAST) begin
                arm_q <= 1'b0;
                st_q  <= S_IDLE;
              end else begin
                ptr_q <= ptr_q + AW'(1);
                st_q  <= (pz_q && mode_q != M_SW) ? S_PAUSE : S_FETCH;
              end
            end
          S_PAUSE: if (trig_i) st_q <= S_FETCH;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (conv_req_o && !conv_done_i && !mode_chg) |=> conv_req_o);
  p_req_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (conv_req_o && conv_done_i) |=> !conv_req_o);
  p_arm_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q != S_IDLE) |=> ($stable(arm_q) || (!arm_q && st_q == S_IDLE)));
  p_abort_r11: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (st_q == S_IDLE && !conv_req_o));
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !ovr_clr_i) |=> ovr_q);
  p_pause_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_PAUSE) |-> trig_mode);
endmodule

// File: rtl/scan_queue_seq.sv
module scan_queue_seq
  import sqs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CH_W  = 6,
  parameter int TMR_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW_W = CH_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             arm_wr_i,
  input  logic             arm_val_i,
  input  logic             ovr_clr_i,
  input  logic             ext_trig_i,
  input  logic [TMR_W-1:0] tmr_period_i,
  input  logic             cw_we_i,
  input  logic [AW-1:0]    cw_addr_i,
  input  logic [CW_W-1:0]  cw_data_i,
  output logic             conv_req_o,
  output logic [CH_W-1:0]  conv_ch_o,
  input  logic             conv_done_i,
  output logic             arm_o,
  output logic [1:0]       status_o,
  output logic             ovr_o
);
  logic            trig;
  logic [AW-1:0]   rd_addr;
  logic [CW_W-1:0] rd_data;

  sqs_trig #(.TMR_W(TMR_W)) u_trig (
    .clk(clk), .rst(rst), .mode_i(mode_i), .ext_i(ext_trig_i),
    .period_i(tmr_period_i), .trig_o(trig)
  );

  sqs_cwmem #(.DEPTH(DEPTH), .CW_W(CW_W)) u_mem (
    .clk(clk), .we(cw_we_i), .waddr(cw_addr_i), .wdata(cw_data_i),
    .raddr(rd_addr), .rdata(rd_data)
  );

  sqs_ctrl #(.DEPTH(DEPTH), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_i), .arm_wr_i(arm_wr_i),
    .arm_val_i(arm_val_i), .ovr_clr_i(ovr_clr_i), .trig_i(trig),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .conv_req_o(conv_req_o),
    .conv_ch_o(conv_ch_o), .conv_done_i(conv_done_i), .arm_o(arm_o),
    .status_o(status_o), .ovr_o(ovr_o)
  );
endmodule

// File: tb/scan_queue_seq_bench.sv
module scan_queue_seq_bench;
  localparam int DEPTH = 16;
  localparam int CH_W  = 6;
  localparam int TMR_W = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [CH_W-1:0] EOQ = {CH_W{1'b1}};

  logic clk = 1'b0;
  logic rst, arm_wr_i, arm_val_i, ovr_clr_i, ext_trig_i, cw_we_i, conv_done_i;
  logic [1:0] mode_i;
  logic [TMR_W-1:0] tmr_period_i;
  logic [AW-1:0] cw_addr_i;
  logic [CH_W:0] cw_data_i;
  logic conv_req_o, arm_o, ovr_o;
  logic [CH_W-1:0] conv_ch_o;
  logic [1:0] status_o;

  int n_chk = 0, n_fail = 0;
  int log_ch [0:63];
  int log_n = 0;
  bit stall = 0, saw_pause = 0, finished = 0;
  logic [CH_W:0] qimg [DEPTH];

  always #5 clk = ~clk;

  scan_queue_seq #(.DEPTH(DEPTH), .CH_W(CH_W), .TMR_W(TMR_W)) u_scan_queue_seq (
    .clk(clk), .rst(rst), .mode_i(mode_i), .arm_wr_i(arm_wr_i), .arm_val_i(arm_val_i),
    .ovr_clr_i(ovr_clr_i), .ext_trig_i(ext_trig_i), .tmr_period_i(tmr_period_i),
    .cw_we_i(cw_we_i), .cw_addr_i(cw_addr_i), .cw_data_i(cw_data_i),
    .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o), .conv_done_i(conv_done_i),
    .arm_o(arm_o), .status_o(status_o), .ovr_o(ovr_o)
  );

  task automatic chk_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: random latency, records each request's channel
  initial begin
    int cnt = 0;
    bit pend = 0;
    conv_done_i = 1'b0;
    forever begin
      @(negedge clk);
      conv_done_i = 1'b0;
      if (status_o == 2'd2) saw_pause = 1;
      if (!conv_req_o) pend = 0;
      else if (!pend) begin
        pend = 1;
        cnt = $urandom % 3;
        if (log_n < 64) log_ch[log_n] = int'(conv_ch_o);
        log_n++;
      end
      if (pend && !stall) begin
        if (cnt == 0) begin conv_done_i = 1'b1; pend = 0; end
        else cnt--;
      end
    end
  end

  function automatic int exp_len();
    for (int i = 0; i < DEPTH; i++) if (qimg[i][CH_W-1:0] == EOQ) return i;
    return DEPTH;
  endfunction

  task automatic load_queue();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      cw_we_i = 1'b1; cw_addr_i = AW'(i); cw_data_i = qimg[i];
    end
    @(negedge clk);
    cw_we_i = 1'b0;
  endtask

  task automatic rand_queue(int len, bit pz);
    for (int i = 0; i < DEPTH; i++)
      qimg[i] = {pz ? 1'($urandom % 2) : 1'b0, CH_W'($urandom % 63)};
    if (len < DEPTH) qimg[len] = {1'b0, EOQ};
  endtask

  task automatic wr_arm(bit v);
    @(negedge clk); arm_wr_i = 1'b1; arm_val_i = v;
    @(negedge clk); arm_wr_i = 1'b0;
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_trig_i = 1'b1;
    repeat (3) @(negedge clk);
    ext_trig_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_log();
    log_n = 0; saw_pause = 0;
  endtask

  task automatic wait_done(string tag);
    int t = 0;
    while (!(arm_o == 1'b0 && status_o == 2'd0) && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk_eq({tag, " timeout"}, t, 0);
  endtask

  task automatic wait_req(string tag);
    int t = 0;
    while (!conv_req_o && t < 200) begin @(negedge clk); t++; end
    if (t >= 200) chk_eq({tag, " no request"}, t, 0);
  endtask

  task automatic wait_pause(string tag);
    int t = 0;
    while (status_o != 2'd2 && t < 500) begin @(negedge clk); t++; end
    if (t >= 500) chk_eq({tag, " no pause"}, t, 0);
  endtask

  task automatic check_scan(string tag);
    int bad = 0;
    int n = exp_len();
    chk_eq({tag, " count"}, log_n, n);
    for (int i = 0; i < n && i < log_n; i++) if (log_ch[i] != int'(qimg[i][CH_W-1:0])) bad++;
    chk_eq({tag, " order"}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; mode_i = 2'd0; arm_wr_i = 0; arm_val_i = 0; ovr_clr_i = 0;
    ext_trig_i = 0; cw_we_i = 0; cw_addr_i = '0; cw_data_i = '0; tmr_period_i = 16'd20;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 status", status_o, 0);
    chk_eq("R1 arm", arm_o, 0);
    chk_eq("R1 ovr", ovr_o, 0);
    chk_eq("R1 req", conv_req_o, 0);

    // R2 R3 R4 random software-mode scans
    mode_i = 2'd1;
    for (int k = 0; k < 8; k++) begin
      rand_queue($urandom % (DEPTH + 1), 1'b1);
      load_queue(); clear_log();
      wr_arm(1'b1); wait_done("R2");
      check_scan("R2");
      chk_eq("R4 arm cleared", arm_o, 0);
      chk_eq("R9 no pause", saw_pause, 0);
    end

    // R3 marker at entry 0
    rand_queue(0, 1'b0); load_queue(); clear_log();
    wr_arm(1'b1); wait_done("R3");
    chk_eq("R3 empty queue", log_n, 0);
    chk_eq("R4 arm after empty", arm_o, 0);

    // R3 R9 full queue, all pause bits set, software mode
    for (int i = 0; i < DEPTH; i++) qimg[i] = {1'b1, CH_W'(i + 3)};
    load_queue(); clear_log();
    wr_arm(1'b1); wait_done("R3");
    check_scan("R3 full");
    chk_eq("R9 pause skipped", saw_pause, 0);

    // R5 arm write mid-scan ignored
    stall = 1; clear_log();
    wr_arm(1'b1); wait_req("R5");
    wr_arm(1'b0);
    chk_eq("R5 arm held", arm_o, 1);
    stall = 0; wait_done("R5");
    chk_eq("R5 scan completed", log_n, DEPTH);

    // R10 no overrun in software mode
    stall = 1; clear_log();
    wr_arm(1'b1); wait_req("R10");
    ext_pulse();
    chk_eq("R10 sw no ovr", ovr_o, 0);
    stall = 0; wait_done("R10");

    // R6 external trigger
    mode_i = 2'd2;
    rand_queue(3, 1'b0); load_queue(); clear_log();
    ext_pulse(); repeat (5) @(negedge clk);
    chk_eq("R6 unarmed edge", log_n, 0);
    chk_eq("R6 unarmed arm", arm_o, 0);
    wr_arm(1'b1); repeat (20) @(negedge clk);
    chk_eq("R6 waits for edge", log_n, 0);
    chk_eq("R6 still armed", arm_o, 1);
    ext_pulse(); wait_done("R6");
    check_scan("R6");
    for (int k = 0; k < 3; k++) begin
      rand_queue(1 + $urandom % DEPTH, 1'b0); load_queue(); clear_log();
      wr_arm(1'b1); ext_pulse(); wait_done("R6");
      check_scan("R6 rand");
    end

    // R8 pause in external mode, R5 write during pause
    for (int i = 0; i < DEPTH; i++) qimg[i] = {1'b0, EOQ};
    qimg[0] = {1'b1, 6'd5}; qimg[1] = {1'b0, 6'd7};
    load_queue(); clear_log();
    wr_arm(1'b1); ext_pulse(); wait_pause("R8");
    chk_eq("R12 pause code", status_o, 2);
    chk_eq("R8 one word before pause", log_n, 1);
    repeat (15) @(negedge clk);
    chk_eq("R8 holds in pause", log_n, 1);
    wr_arm(1'b0);
    chk_eq("R5 arm held in pause", arm_o, 1);
    ext_pulse(); wait_done("R8");
    chk_eq("R8 resumed count", log_n, 2);
    chk_eq("R8 resumed channel", log_ch[1], 7);

    // R10 overrun in external mode
    rand_queue(3, 1'b0); load_queue(); clear_log();
    stall = 1;
    wr_arm(1'b1); ext_pulse(); wait_req("R10");
    ext_pulse();
    chk_eq("R10 ovr set", ovr_o, 1);
    stall = 0; wait_done("R10");
    chk_eq("R10 ovr sticky", ovr_o, 1);
    @(negedge clk); ovr_clr_i = 1; @(negedge clk); ovr_clr_i = 0;
    chk_eq("R10 ovr cleared", ovr_o, 0);

    // R7 timer mode
    mode_i = 2'd3;
    rand_queue(4, 1'b0); load_queue(); clear_log();
    begin
      int t = 0;
      wr_arm(1'b1);
      while (!conv_req_o && t < 100) begin @(negedge clk); t++; end
      chk_eq("R7 start within period", int'(t <= 25), 1);
    end
    wait_done("R7");
    check_scan("R7");

    // R8 pause in timer mode
    for (int i = 0; i < DEPTH; i++) qimg[i] = {1'b0, EOQ};
    qimg[0] = {1'b1, 6'd9}; qimg[1] = {1'b0, 6'd11};
    load_queue(); clear_log();
    wr_arm(1'b1); wait_pause("R8 tmr");
    chk_eq("R8 tmr paused count", log_n, 1);
    wait_done("R8 tmr");
    chk_eq("R8 tmr resumed", log_n, 2);

    // R11 mode change aborts, new mode evaluates held arm bit
    mode_i = 2'd1;
    for (int i = 0; i < DEPTH; i++) qimg[i] = {1'b0, CH_W'(20 + i)};
    load_queue(); clear_log();
    stall = 1;
    wr_arm(1'b1); wait_req("R11");
    repeat (2) @(negedge clk);
    mode_i = 2'd0;
    @(negedge clk);
    chk_eq("R11 req dropped", conv_req_o, 0);
    chk_eq("R11 status idle", status_o, 0);
    chk_eq("R11 arm kept", arm_o, 1);
    repeat (5) @(negedge clk);
    clear_log(); stall = 0;
    mode_i = 2'd1;
    wait_done("R11");
    chk_eq("R11 restart count", log_n, DEPTH);
    chk_eq("R11 restart first", log_ch[0], 20);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule